// File: doc/BRIEF.md
# Interrupt Context Save Unit

This block keeps the return context a processor core needs when it enters a subroutine or services an interrupt. A last-in first-out stack of program-counter values takes a push on every subroutine entry and on every interrupt service. It gives one back on every return. Beside the stack sits a bank of one-deep shadow copies of eleven core registers, such as the accumulator, its buffer, the product register and the status words. The bank takes a snapshot of the live values only when an interrupt is serviced.

A return from interrupt pops the program counter and replays the snapshot onto a parallel restore bus, one cycle later, with a one-cycle valid strobe. The register file takes the values from that bus. An ordinary return only pops the program counter. The bank is one level deep, so a nested interrupt replaces the earlier snapshot. The register file itself lives outside this block.

Top module: `ctx_save_unit`

## Requirements
- R1: Pops return program-counter values in reverse order of their pushes. `ret_pc` carries the value and `ret_pc_valid` is high for exactly the one cycle after a pop strobe. The stack holds up to 8 entries.
- R2: Both `irq_take` and `call_push` push `push_pc` onto the stack.
- R3: `irq_take` captures every live register into its shadow copy. `call_push` leaves the shadow copies unchanged.
- R4: `reti_pop` pops the program counter. In the cycle after the strobe, `restore_regs` carries the shadow contents and `restore_valid` is high for that one cycle.
- R5: `ret_pop` pops the program counter only. `restore_valid` stays low, `restore_regs` keeps its value, and the shadow copies are unchanged, as a later `reti_pop` shows.
- R6: A second `irq_take` before any `reti_pop` overwrites the shadow copies. Every following `reti_pop` replays the newest snapshot until another capture takes place.
- R7: A push onto a full stack discards the oldest entry and keeps the 8 newest. It also sets `overflow`, which stays high until reset.
- R8: A pop from an empty stack leaves `ret_pc` at its last popped value. `underflow` and `ret_pc_valid` are both high for the following cycle. A `reti_pop` on an empty stack still restores the shadows.
- R9: When several strobes are high in the same cycle, only the first in the order `irq_take`, `call_push`, `reti_pop`, `ret_pop` acts. The others are ignored.
- R10: After reset the stack is empty, the shadow copies are zero, and every output is zero.
- R11: Register k (k = 0..10) occupies bits [16k+15:16k] of both `live_regs` and `restore_regs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_take | input | 1 | Interrupt serviced: push PC and capture shadows |
| call_push | input | 1 | Subroutine entered: push PC |
| reti_pop | input | 1 | Return from interrupt: pop PC and restore shadows |
| ret_pop | input | 1 | Ordinary return: pop PC |
| push_pc | input | 16 | Program counter value to push |
| live_regs | input | 176 | Live values of the eleven shadowed registers |
| ret_pc | output | 16 | Popped program counter |
| ret_pc_valid | output | 1 | One-cycle strobe after any pop |
| overflow | output | 1 | Sticky: a push found the stack full |
| underflow | output | 1 | One-cycle strobe: a pop found the stack empty |
| restore_regs | output | 176 | Restored register values |
| restore_valid | output | 1 | One-cycle strobe: restore_regs was just loaded |

## Verification
The bench builds the unit with its default parameters: 16-bit program counter and register width, a stack depth of 8 and eleven shadowed registers. A depth of 8 means that ten straight pushes already wrap the circular storage and reach overflow. Draining from that point reaches underflow within a few dozen cycles. The full 176-bit restore bus is compared on every clock, so a slice at the wrong bit position or a stale capture shows up directly. Directed phases cover nesting, priority and both empty and full stacks. A random phase then mixes all four strobes.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_IRQ,
      OP_CALL,
      OP_RETI,
      OP_RET
   } ctx_op_e;

   // fixed precedence between simultaneous strobes
   function automatic ctx_op_e ctx_decode(input logic irq, input logic call,
                                          input logic reti, input logic ret);
      if (irq)       return OP_IRQ;
      else if (call) return OP_CALL;
      else if (reti) return OP_RETI;
      else if (ret)  return OP_RET;
      return OP_NONE;
   endfunction

endpackage

// File: rtl/ctx_pc_stack.sv
module ctx_pc_stack #(
   parameter int PC_W  = 16,
   parameter int DEPTH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic            pop,
   input  logic [PC_W-1:0] push_pc,
   output logic [PC_W-1:0] pop_pc,
   output logic            pop_valid,
   output logic            overflow,
   output logic            underflow
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic [PC_W-1:0]  mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] top_ptr;
   logic [PTR_W-1:0] nxt_ptr;
   logic [CNT_W-1:0] count;
   logic             empty;

   assign top_ptr = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
   assign nxt_ptr = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
   assign empty   = (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         wr_ptr    <= '0;
         count     <= '0;
         pop_pc    <= '0;
         pop_valid <= 1'b0;
         overflow  <= 1'b0;
         underflow <= 1'b0;
      end else begin
         pop_valid <= pop;
         underflow <= pop && empty;
         if (push) begin
            // circular storage: a full stack overwrites its oldest slot
            mem[wr_ptr] <= push_pc;
            wr_ptr      <= nxt_ptr;
            if (count == FULL) overflow <= 1'b1;
            else               count    <= count + 1'b1;
         end else if (pop && !empty) begin
            pop_pc <= mem[top_ptr];
            wr_ptr <= top_ptr;
            count  <= count - 1'b1;
         end
      end
   end
endmodule

// File: rtl/ctx_shadow_bank.sv
module ctx_shadow_bank #(
   parameter int DATA_W = 16,
   parameter int NUM    = 11
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  capture,
   input  logic                  restore,
   input  logic [NUM*DATA_W-1:0] live_flat,
   output logic [NUM*DATA_W-1:0] rest_flat,
   output logic                  rest_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rest_valid <= 1'b0;
      else        rest_valid <= restore;
   end

   for (genvar g = 0; g < NUM; g++) begin : g_slot
      logic [DATA_W-1:0] shadow_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       shadow_q <= '0;
         else if (capture) shadow_q <= live_flat[g*DATA_W +: DATA_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       rest_flat[g*DATA_W +: DATA_W] <= '0;
         else if (restore) rest_flat[g*DATA_W +: DATA_W] <= shadow_q;
      end
   end
endmodule

// File: rtl/ctx_save_unit.sv
module ctx_save_unit
   import ctx_save_pkg::*;
#(
   parameter int PC_W    = 16,
   parameter int DATA_W  = 16,
   parameter int DEPTH   = 8,
   parameter int NUM_REG = 11
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      irq_take,
   input  logic                      call_push,
   input  logic                      reti_pop,
   input  logic                      ret_pop,
   input  logic [PC_W-1:0]           push_pc,
   input  logic [NUM_REG*DATA_W-1:0] live_regs,
   output logic [PC_W-1:0]           ret_pc,
   output logic                      ret_pc_valid,
   output logic                      overflow,
   output logic                      underflow,
   output logic [NUM_REG*DATA_W-1:0] restore_regs,
   output logic                      restore_valid
);
   if (DEPTH < 2)   $error("ctx_save_unit: DEPTH must be at least 2");
   if (PC_W < 1)    $error("ctx_save_unit: PC_W must be positive");
   if (DATA_W < 1)  $error("ctx_save_unit: DATA_W must be positive");
   if (NUM_REG < 1) $error("ctx_save_unit: NUM_REG must be positive");

   ctx_op_e op;
   logic    do_push, do_pop, do_cap, do_rest;

   assign op      = ctx_decode(irq_take, call_push, reti_pop, ret_pop);
   assign do_push = (op == OP_IRQ) || (op == OP_CALL);
   assign do_pop  = (op == OP_RETI) || (op == OP_RET);
   assign do_cap  = (op == OP_IRQ);
   assign do_rest = (op == OP_RETI);

   ctx_pc_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (do_push),
      .pop       (do_pop),
      .push_pc   (push_pc),
      .pop_pc    (ret_pc),
      .pop_valid (ret_pc_valid),
      .overflow  (overflow),
      .underflow (underflow)
   );

   ctx_shadow_bank #(.DATA_W(DATA_W), .NUM(NUM_REG)) u_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (do_cap),
      .restore    (do_rest),
      .live_flat  (live_regs),
      .rest_flat  (restore_regs),
      .rest_valid (restore_valid)
   );
endmodule

// File: rtl/ctx_save_chk.sv
module ctx_save_chk #(
   parameter int PC_W    = 16,
   parameter int DATA_W  = 16,
   parameter int DEPTH   = 8,
   parameter int NUM_REG = 11
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      irq_take,
   input logic                      call_push,
   input logic                      reti_pop,
   input logic                      ret_pop,
   input logic [PC_W-1:0]           push_pc,
   input logic [NUM_REG*DATA_W-1:0] live_regs,
   input logic [PC_W-1:0]           ret_pc,
   input logic                      ret_pc_valid,
   input logic                      overflow,
   input logic                      underflow,
   input logic [NUM_REG*DATA_W-1:0] restore_regs,
   input logic                      restore_valid
);
   logic pop_req, reti_req;
   assign pop_req  = !irq_take && !call_push && (reti_pop || ret_pop);
   assign reti_req = !irq_take && !call_push && reti_pop;

   AST_POP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      pop_req |=> ret_pc_valid);                                   // R1
   AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_req |=> !ret_pc_valid);                                  // R9
   AST_RESTORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      reti_req |=> restore_valid);                                  // R4
   AST_RESTORE_ONLY_RETI: assert property (@(posedge clk) disable iff (!rst_n)
      !reti_req |=> !restore_valid);                                // R5
   AST_RESTORE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !restore_valid |-> $stable(restore_regs));                    // R5
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);                                       // R7
   AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> ret_pc_valid && $stable(ret_pc));               // R8
endmodule

bind ctx_save_unit ctx_save_chk #(
   .PC_W(PC_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .NUM_REG(NUM_REG)
) u_chk (.*);

// File: tb/ctx_save_unit_bench.sv
module ctx_save_unit_bench;
   localparam int PC_W = 16;
   localparam int DW   = 16;
   localparam int DEP  = 8;
   localparam int NR   = 11;
   localparam int LW   = NR * DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          irq_i = 0, call_i = 0, reti_i = 0, ret_i = 0;
   logic [PC_W-1:0] pc_i = '0;
   logic [LW-1:0] live_i = '0;
   logic [PC_W-1:0] ret_pc;
   logic          ret_pc_valid, overflow, underflow, restore_valid;
   logic [LW-1:0] restore_regs;

   always #2ns clk = ~clk;

   ctx_save_unit u_ctx_save_unit (
      .clk(clk), .rst_n(rst_n), .irq_take(irq_i), .call_push(call_i),
      .reti_pop(reti_i), .ret_pop(ret_i), .push_pc(pc_i), .live_regs(live_i),
      .ret_pc(ret_pc), .ret_pc_valid(ret_pc_valid), .overflow(overflow),
      .underflow(underflow), .restore_regs(restore_regs),
      .restore_valid(restore_valid)
   );

   int    errors = 0;
   int    checks = 0;
   bit    done = 0;
   bit    cmp_on = 0;
   string phase = "reset";

   // behavioural reference
   logic [PC_W-1:0] q[$];
   logic [PC_W-1:0] m_pc;
   logic [LW-1:0]   m_shadow, m_rest;
   logic            m_pcv, m_ovf, m_uf, m_rv;

   task automatic m_push(input logic [PC_W-1:0] v);
      if (q.size() == DEP) begin
         void'(q.pop_front());
         m_ovf = 1'b1;
      end
      q.push_back(v);
   endtask

   task automatic m_pop();
      m_pcv = 1'b1;
      if (q.size() > 0) m_pc = q.pop_back();
      else              m_uf = 1'b1;
   endtask

   always @(posedge clk or negedge rst_n) begin
      m_pcv = 0; m_uf = 0; m_rv = 0;
      if (!rst_n) begin
         q.delete();
         m_pc = '0; m_ovf = 0; m_shadow = '0; m_rest = '0;
      end else if (irq_i) begin
         m_push(pc_i);
         m_shadow = live_i;
      end else if (call_i) m_push(pc_i);
      else if (reti_i) begin
         m_pop();
         m_rest = m_shadow;
         m_rv   = 1'b1;
      end else if (ret_i) m_pop();
   end

   task automatic chk(input string req, input string what,
                      input logic [LW-1:0] act, input logic [LW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s (%s): actual=%0h expected=%0h", req, what, phase, act, exp);
      end
   endtask

   always @(negedge clk) if (cmp_on) begin
      chk("R1", "ret_pc", LW'(ret_pc), LW'(m_pc));
      chk("R1", "ret_pc_valid", LW'(ret_pc_valid), LW'(m_pcv));
      chk("R7", "overflow", LW'(overflow), LW'(m_ovf));
      chk("R8", "underflow", LW'(underflow), LW'(m_uf));
      chk("R4", "restore_valid", LW'(restore_valid), LW'(m_rv));
      chk("R11", "restore_regs", restore_regs, m_rest);
   end

   function automatic logic [LW-1:0] pat(input int seed);
      logic [LW-1:0] v;
      for (int k = 0; k < NR; k++) v[k*DW +: DW] = DW'(seed * 16'h0101 + k * 16'h0111 + 1);
      return v;
   endfunction

   task automatic step(input logic irq, input logic call, input logic reti,
                       input logic ret, input logic [PC_W-1:0] pc,
                       input logic [LW-1:0] live);
      irq_i = irq; call_i = call; reti_i = reti; ret_i = ret; pc_i = pc; live_i = live;
      @(negedge clk);
      irq_i = 0; call_i = 0; reti_i = 0; ret_i = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "reset ret_pc", LW'(ret_pc), '0);
      chk("R10", "reset flags", LW'({ret_pc_valid, overflow, underflow, restore_valid}), '0);
      chk("R10", "reset restore_regs", restore_regs, '0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      idle(1);

      // R2 R1: both push kinds feed one LIFO
      phase = "R2 push kinds";
      step(0, 1, 0, 0, 16'h0100, '0);
      step(0, 1, 0, 0, 16'h0200, '0);
      step(1, 0, 0, 0, 16'h0300, pat(1));
      step(0, 0, 0, 1, '0, '0);
      step(0, 0, 0, 1, '0, '0);
      step(0, 0, 0, 1, '0, '0);
      idle(1);

      // R3 R4: capture on irq only, replay on reti
      phase = "R3 capture";
      step(1, 0, 0, 0, 16'h0410, pat(2));
      step(0, 1, 0, 0, 16'h0420, pat(3));
      step(0, 0, 0, 1, '0, pat(4));
      step(0, 0, 1, 0, '0, pat(5));
      idle(2);

      // R5: plain return leaves shadows alone
      phase = "R5 plain ret";
      step(1, 0, 0, 0, 16'h0510, pat(6));
      step(0, 0, 0, 1, '0, pat(7));
      idle(1);
      step(0, 1, 0, 0, 16'h0520, pat(8));
      step(0, 0, 1, 0, '0, '0);
      idle(1);

      // R6: nesting overwrites the single-level copy
      phase = "R6 nesting";
      step(1, 0, 0, 0, 16'h0610, pat(9));
      step(1, 0, 0, 0, 16'h0620, pat(10));
      step(0, 0, 1, 0, '0, '0);
      step(0, 0, 1, 0, '0, '0);
      idle(1);

      // R9: simultaneous strobes
      phase = "R9 priority";
      step(1, 1, 1, 1, 16'h0910, pat(11));
      step(0, 1, 1, 1, 16'h0920, pat(12));
      step(0, 0, 1, 1, '0, pat(13));
      step(0, 0, 1, 1, '0, '0);
      idle(1);

      // R7 R8: overflow then drain past empty
      phase = "R7 overflow";
      for (int i = 0; i < DEP + 2; i++) step(0, 1, 0, 0, PC_W'(16'h0700 + i), '0);
      phase = "R8 underflow";
      for (int i = 0; i < DEP + 2; i++) step(0, 0, 0, 1, '0, '0);
      step(0, 0, 1, 0, '0, '0);
      idle(2);

      // mixed traffic
      phase = "random R1 R9";
      for (int i = 0; i < 600; i++) begin
         logic [3:0] s;
         s = 4'($urandom);
         step(s[0] & s[1], s[2], s[3], s[1], PC_W'($urandom), pat(int'($urandom % 200)));
      end
      idle(2);

      cmp_on = 1'b0;
      // R10: reset again mid-run
      rst_n = 1'b0;
      idle(1);
      chk("R10", "re-reset flags", LW'({ret_pc_valid, overflow, underflow, restore_valid}), '0);
      chk("R10", "re-reset restore_regs", restore_regs, '0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule